// File: doc/BRIEF.md
# Two-Level 32-bit Page-Table Walker with Widened Guest Stage

This block walks two-level page tables for 32-bit virtual memory with 4 KiB pages and 4-byte entries. One walker serves three kinds of request: a plain first-stage walk of a virtual address; a second-stage walk of a guest-physical address, whose root index is two bits wider so that guest-physical space reaches 34 bits; and a nested first-stage walk. In the nested walk, every table base is first translated through a complete second-stage walk before the entry address is formed.

A request is accepted in one cycle while the walker is idle. Page-table entries are fetched through a read port that allows one outstanding read. The result comes back as a one-cycle pulse. It carries the translated address, the read/write/execute permissions and two fault flags. A faulting walk reports all permissions clear.

Top module: `sv32w_walker`

## Requirements
- R1: In mode 0 the root entry is read at `root<<12 + vaddr[31:22]*4` and a pointer entry leads to a read at `ptr<<12 + vaddr[21:12]*4`. A leaf there yields `{leaf_ppn, vaddr[11:0]}`. Entry bits: V=0, R=1, W=2, X=3, U=4, page number in [31:10].
- R2: Input address bits from the top translated bit (bit 31 in modes 0 and 2, bit 33 in mode 1) up to the top input bit must all be equal. If they are not, the walk faults with no memory read.
- R3: In mode 1 the root index is the 12 bits `gaddr[33:22]`, the second index is `gaddr[21:12]`, and the root base comes from the guest-stage root input.
- R4: A second-stage leaf is always checked as a user access. A leaf with U clear faults even for a supervisor requester. Every second-stage failure, including a range failure in mode 1, sets both `done_fault` and `done_fault_g`.
- R5: Read permission is R, or X together with make-executable-readable. That flag is `mxr_s` for first-stage leaves and `mxr_vs` for second-stage leaves. Write equals W and execute equals X.
- R6: A leaf at the root level is a superpage. The low page-number bits it covers are ORed into the output page number: 10 bits in the first stage, 12 bits (including the two widened bits) in the second stage.
- R7: An entry with V clear, or with W set and R clear, faults. A faulting walk reports `perm_r`, `perm_w` and `perm_x` all zero.
- R8: A pointer entry (V set, R and X clear) at the second level faults.
- R9: A root-level leaf whose page number bits [9:0] are not zero faults as a misaligned superpage.
- R10: In mode 2 each table base is translated through a full second-stage walk before that level's entry is read. A failure inside that walk sets `done_fault_g`. The resulting address is guest-physical.
- R11: First-stage walks start from `root_vs` when `sel_vs_root` is 1, and from `root_s` otherwise.
- R12: The read request holds its address until accepted. At most one read is outstanding. No request is made while idle. `done_valid` is a single-cycle pulse.
- R13: A first-stage leaf with U clear faults when `priv_user` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| walk_valid | input | 1 | Start a walk (taken when walk_ready) |
| walk_ready | output | 1 | Walker idle |
| walk_mode | input | 2 | 0 first stage, 1 second stage, 2 nested first stage, 3 treated as 0 |
| walk_addr | input | IN_W | Virtual or guest-physical address |
| priv_user | input | 1 | First-stage requester is user level |
| sel_vs_root | input | 1 | Use the virtual-supervisor root for first stage |
| mxr_s | input | 1 | Make-executable-readable for first stage |
| mxr_vs | input | 1 | Make-executable-readable for second stage |
| root_s | input | 22 | First-stage root page number |
| root_vs | input | 22 | Virtual-supervisor root page number |
| root_g | input | 22 | Guest-stage root page number |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | 34 | Entry byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read data |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | Walk failed |
| done_fault_g | output | 1 | Failure came from a second-stage lookup |
| done_pa | output | 34 | Translated address |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |

## Verification
The assertions watch the read-port protocol on every cycle: the address is held while the request waits, only one read is in flight, and the port stays quiet while the walker is idle. They also check that results arrive as single pulses, that a guest-stage fault always comes with the general fault flag, and that faulting walks grant no permissions. Only the directed scenarios can show that the right entry addresses are read in the right order, and that superpage merging uses the correct width in each stage. They alone also cover the effect of the mode-dependent flag selection and the nested translation of each table base.

// File: rtl/sv32w_pkg.sv
package sv32w_pkg;
    localparam int PG_SHIFT   = 12;
    localparam int IDX_W      = 10;
    localparam int WIDEN      = 2;
    localparam int PTE_LOG    = 2;
    localparam int PTE_W      = 8 << PTE_LOG;
    localparam int ROOT_IDX_W = IDX_W + WIDEN;
    localparam int VA1_W      = PG_SHIFT + 2 * IDX_W;
    localparam int VA2_W      = VA1_W + WIDEN;
    localparam int PPN_W      = VA2_W - PG_SHIFT;
    localparam int PA_W       = PPN_W + PG_SHIFT;
    localparam int PPN_LSB    = PTE_W - PPN_W;

    typedef enum logic [1:0] {
        MD_S1   = 2'd0,
        MD_S2   = 2'd1,
        MD_NEST = 2'd2,
        MD_RSVD = 2'd3
    } walk_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_REQ, ST_WAIT, ST_GREQ, ST_GWAIT, ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic             fault;
        logic             leaf;
        logic [PPN_W-1:0] ppn;
        logic             pr;
        logic             pw;
        logic             px;
    } pte_res_t;
endpackage

// File: rtl/sv32w_span_chk.sv
// Checks that every address bit from TOP upward carries the same value.
module sv32w_span_chk #(
    parameter int IN_W = 40,
    parameter int TOP  = 31
) (
    input  logic [IN_W-1:0] addr,
    output logic            ok
);
    generate
        if (IN_W > TOP + 1) begin : g_check
            logic [IN_W-1-TOP:0] hi;
            assign hi = addr[IN_W-1:TOP];
            assign ok = (&hi) | ~(|hi);
        end else begin : g_skip
            assign ok = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/sv32w_pte_addr.sv
// Entry address = base page << shift + index * entry size.
module sv32w_pte_addr
    import sv32w_pkg::*;
(
    input  logic [PPN_W-1:0]      base,
    input  logic [ROOT_IDX_W-1:0] idx,
    output logic [PA_W-1:0]       addr
);
    localparam int PAD_W = PA_W - ROOT_IDX_W - PTE_LOG;

    assign addr = {base, {PG_SHIFT{1'b0}}}
                + {{PAD_W{1'b0}}, idx, {PTE_LOG{1'b0}}};
endmodule

// File: rtl/sv32w_pte_eval.sv
// Decodes one fetched entry: fault, leaf, output page number, permissions.
module sv32w_pte_eval
    import sv32w_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic             is_root,
    input  logic             g_stage,
    input  logic             user,
    input  logic             mxr,
    input  logic [PPN_W-1:0] vpn,
    output pte_res_t         res
);
    localparam logic [PPN_W-1:0] MASK_S1 = {{(PPN_W-IDX_W){1'b0}}, {IDX_W{1'b1}}};
    localparam logic [PPN_W-1:0] MASK_S2 = {{(PPN_W-ROOT_IDX_W){1'b0}}, {ROOT_IDX_W{1'b1}}};

    logic             v_b, r_b, w_b, x_b, u_b;
    logic [PPN_W-1:0] ppn;
    logic [PPN_W-1:0] low_mask;

    assign v_b      = pte[0];
    assign r_b      = pte[1];
    assign w_b      = pte[2];
    assign x_b      = pte[3];
    assign u_b      = pte[4];
    assign ppn      = pte[PTE_W-1:PPN_LSB];
    assign low_mask = g_stage ? MASK_S2 : MASK_S1;

    always_comb begin
        res     = '0;
        res.ppn = ppn;
        if (!v_b || (w_b && !r_b)) begin
            res.fault = 1'b1;
        end else if (r_b || x_b) begin
            res.leaf = 1'b1;
            if (user && !u_b) begin
                res.fault = 1'b1;
            end
            if (is_root && (|ppn[IDX_W-1:0])) begin
                res.fault = 1'b1;
            end
            if (is_root) begin
                res.ppn = ppn | (vpn & low_mask);
            end
            if (!res.fault) begin
                res.pr = r_b | (x_b & mxr);
                res.pw = w_b;
                res.px = x_b;
            end
        end else if (!is_root) begin
            res.fault = 1'b1;
        end
    end
endmodule

// File: rtl/sv32w_walker.sv
module sv32w_walker
    import sv32w_pkg::*;
#(
    parameter int IN_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             walk_valid,
    output logic             walk_ready,
    input  logic [1:0]       walk_mode,
    input  logic [IN_W-1:0]  walk_addr,
    input  logic             priv_user,
    input  logic             sel_vs_root,
    input  logic             mxr_s,
    input  logic             mxr_vs,
    input  logic [PPN_W-1:0] root_s,
    input  logic [PPN_W-1:0] root_vs,
    input  logic [PPN_W-1:0] root_g,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done_valid,
    output logic             done_fault,
    output logic             done_fault_g,
    output logic [PA_W-1:0]  done_pa,
    output logic             perm_r,
    output logic             perm_w,
    output logic             perm_x
);
    localparam int IDX_PAD = ROOT_IDX_W - IDX_W;

    typedef struct packed {
        walk_st_e         st;
        walk_mode_e       mode;
        logic [VA2_W-1:0] va;
        logic             user;
        logic             mxr_s;
        logic             mxr_vs;
        logic             lvl;
        logic [PPN_W-1:0] tbase;
        logic [PPN_W-1:0] groot;
        logic             glvl;
        logic [PPN_W-1:0] gbase;
        logic [PA_W-1:0]  gpa;
        logic             fault;
        logic             fault_g;
        logic [PPN_W-1:0] ppn;
        logic             pr;
        logic             pw;
        logic             px;
    } walk_reg_t;

    walk_reg_t q, d;

    logic                  s1_ok, s2_ok;
    logic [PPN_W-1:0]      s1_root;
    logic [PPN_W-1:0]      a_base;
    logic [ROOT_IDX_W-1:0] a_idx;
    logic                  g_phase;
    logic                  ev_root, ev_user, ev_mxr;
    logic [PPN_W-1:0]      ev_vpn;
    pte_res_t              ev;

    sv32w_span_chk #(.IN_W(IN_W), .TOP(VA1_W-1)) u_span1 (
        .addr (walk_addr),
        .ok   (s1_ok)
    );

    sv32w_span_chk #(.IN_W(IN_W), .TOP(VA2_W-1)) u_span2 (
        .addr (walk_addr),
        .ok   (s2_ok)
    );

    assign s1_root = sel_vs_root ? root_vs : root_s;
    assign g_phase = (q.st == ST_GREQ) || (q.st == ST_GWAIT);

    // Entry address for the level currently being fetched
    always_comb begin
        if (g_phase) begin
            a_base = q.gbase;
            a_idx  = q.glvl ? q.gpa[PA_W-1:PG_SHIFT+IDX_W]
                            : {{IDX_PAD{1'b0}}, q.gpa[PG_SHIFT+IDX_W-1:PG_SHIFT]};
        end else begin
            a_base = q.tbase;
            a_idx  = q.lvl ? {{IDX_PAD{1'b0}}, q.va[VA1_W-1:PG_SHIFT+IDX_W]}
                           : {{IDX_PAD{1'b0}}, q.va[PG_SHIFT+IDX_W-1:PG_SHIFT]};
        end
    end

    sv32w_pte_addr u_addr (
        .base (a_base),
        .idx  (a_idx),
        .addr (mem_req_addr)
    );

    // Entry evaluation context
    always_comb begin
        if (g_phase) begin
            ev_root = q.glvl;
            ev_user = 1'b1;
            ev_mxr  = q.mxr_vs;
            ev_vpn  = q.gpa[PA_W-1:PG_SHIFT];
        end else begin
            ev_root = q.lvl;
            ev_user = q.user;
            ev_mxr  = q.mxr_s;
            ev_vpn  = {{WIDEN{1'b0}}, q.va[VA1_W-1:PG_SHIFT]};
        end
    end

    sv32w_pte_eval u_eval (
        .pte     (mem_rsp_data),
        .is_root (ev_root),
        .g_stage (g_phase),
        .user    (ev_user),
        .mxr     (ev_mxr),
        .vpn     (ev_vpn),
        .res     (ev)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (walk_valid) begin
                    d.va      = walk_addr[VA2_W-1:0];
                    d.user    = priv_user;
                    d.mxr_s   = mxr_s;
                    d.mxr_vs  = mxr_vs;
                    d.groot   = root_g;
                    d.fault   = 1'b0;
                    d.fault_g = 1'b0;
                    d.ppn     = '0;
                    d.pr      = 1'b0;
                    d.pw      = 1'b0;
                    d.px      = 1'b0;
                    d.lvl     = 1'b1;
                    d.glvl    = 1'b1;
                    d.gbase   = root_g;
                    case (walk_mode_e'(walk_mode))
                        MD_S2: begin
                            d.mode = MD_S2;
                            d.gpa  = walk_addr[PA_W-1:0];
                            if (!s2_ok) begin
                                d.fault   = 1'b1;
                                d.fault_g = 1'b1;
                                d.st      = ST_DONE;
                            end else begin
                                d.st = ST_GREQ;
                            end
                        end
                        MD_NEST: begin
                            d.mode = MD_NEST;
                            d.gpa  = {s1_root, {PG_SHIFT{1'b0}}};
                            if (!s1_ok) begin
                                d.fault = 1'b1;
                                d.st    = ST_DONE;
                            end else begin
                                d.st = ST_GREQ;
                            end
                        end
                        default: begin
                            d.mode  = MD_S1;
                            d.tbase = s1_root;
                            if (!s1_ok) begin
                                d.fault = 1'b1;
                                d.st    = ST_DONE;
                            end else begin
                                d.st = ST_REQ;
                            end
                        end
                    endcase
                end
            end
            ST_REQ: begin
                if (mem_req_ready) d.st = ST_WAIT;
            end
            ST_GREQ: begin
                if (mem_req_ready) d.st = ST_GWAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ev.fault) begin
                        d.fault = 1'b1;
                        d.st    = ST_DONE;
                    end else if (ev.leaf) begin
                        d.ppn = ev.ppn;
                        d.pr  = ev.pr;
                        d.pw  = ev.pw;
                        d.px  = ev.px;
                        d.st  = ST_DONE;
                    end else begin
                        d.lvl = 1'b0;
                        if (q.mode == MD_NEST) begin
                            d.gpa   = {ev.ppn, {PG_SHIFT{1'b0}}};
                            d.glvl  = 1'b1;
                            d.gbase = q.groot;
                            d.st    = ST_GREQ;
                        end else begin
                            d.tbase = ev.ppn;
                            d.st    = ST_REQ;
                        end
                    end
                end
            end
            ST_GWAIT: begin
                if (mem_rsp_valid) begin
                    if (ev.fault) begin
                        d.fault   = 1'b1;
                        d.fault_g = 1'b1;
                        d.st      = ST_DONE;
                    end else if (ev.leaf) begin
                        if (q.mode == MD_S2) begin
                            d.ppn = ev.ppn;
                            d.pr  = ev.pr;
                            d.pw  = ev.pw;
                            d.px  = ev.px;
                            d.st  = ST_DONE;
                        end else begin
                            d.tbase = ev.ppn;
                            d.st    = ST_REQ;
                        end
                    end else begin
                        d.glvl  = 1'b0;
                        d.gbase = ev.ppn;
                        d.st    = ST_GREQ;
                    end
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.mode <= MD_S1;
        end else begin
            q <= d;
        end
    end

    assign walk_ready    = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st == ST_REQ) || (q.st == ST_GREQ);
    assign done_valid    = (q.st == ST_DONE);
    assign done_fault    = q.fault;
    assign done_fault_g  = q.fault_g;
    assign done_pa       = {q.ppn, q.va[PG_SHIFT-1:0]};
    assign perm_r        = q.pr;
    assign perm_w        = q.pw;
    assign perm_x        = q.px;
endmodule

// File: rtl/sv32w_walker_chk.sv
module sv32w_walker_chk
    import sv32w_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            walk_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            done_valid,
    input logic            done_fault,
    input logic            done_fault_g,
    input logic            perm_r,
    input logic            perm_w,
    input logic            perm_x
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            pend_q <= 1'b1;
        end else if (mem_rsp_valid) begin
            pend_q <= 1'b0;
        end
    end

    a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |-> !pend_q);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        walk_ready |-> !mem_req_valid);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    a_r4_guest_flag_implies_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault_g) |-> done_fault);

    a_r7_fault_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |-> !(perm_r || perm_w || perm_x));
endmodule

bind sv32w_walker sv32w_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .walk_ready    (walk_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_fault_g  (done_fault_g),
    .perm_r        (perm_r),
    .perm_w        (perm_w),
    .perm_x        (perm_x)
);

// File: tb/tb_sv32w_walker.sv
module tb_sv32w_walker;
    localparam int IN_W = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_valid = 1'b0;
    logic        walk_ready;
    logic [1:0]  walk_mode = 2'd0;
    logic [IN_W-1:0] walk_addr = '0;
    logic        priv_user = 1'b0, sel_vs_root = 1'b0, mxr_s = 1'b0, mxr_vs = 1'b0;
    logic [21:0] root_s = 22'h00100, root_vs = 22'h00200, root_g = 22'h00300;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid, done_fault, done_fault_g;
    logic [33:0] done_pa;
    logic        perm_r, perm_w, perm_x;

    int n_checks = 0;
    int n_fail = 0;

    logic [31:0] mem [logic [33:0]];
    logic        pend = 1'b0;
    logic [33:0] paddr = '0;
    int          n_rd = 0;
    logic [33:0] rd_log [0:7];

    logic        r_fault, r_fg, r_pr, r_pw, r_px;
    logic [33:0] r_pa;

    sv32w_walker #(.IN_W(IN_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .walk_valid(walk_valid), .walk_ready(walk_ready),
        .walk_mode(walk_mode), .walk_addr(walk_addr),
        .priv_user(priv_user), .sel_vs_root(sel_vs_root),
        .mxr_s(mxr_s), .mxr_vs(mxr_vs),
        .root_s(root_s), .root_vs(root_vs), .root_g(root_g),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_fault(done_fault), .done_fault_g(done_fault_g),
        .done_pa(done_pa), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] mk(input logic [21:0] ppn, input logic [9:0] fl);
        return {ppn, fl};
    endfunction

    // Memory responder: one read in flight, data one cycle after acceptance
    initial begin
        forever begin
            @(negedge clk);
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem.exists(paddr) ? mem[paddr] : 32'h0;
                pend          = 1'b0;
            end else begin
                mem_rsp_valid = 1'b0;
                if (mem_req_valid) begin
                    pend  = 1'b1;
                    paddr = mem_req_addr;
                    if (n_rd < 8) rd_log[n_rd] = mem_req_addr;
                    n_rd++;
                end
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] md, input logic [IN_W-1:0] a,
                       input logic usr, input logic vs, input logic ms, input logic mv);
        bit seen = 1'b0;
        @(negedge clk);
        n_rd        = 0;
        walk_mode   = md;
        walk_addr   = a;
        priv_user   = usr;
        sel_vs_root = vs;
        mxr_s       = ms;
        mxr_vs      = mv;
        walk_valid  = 1'b1;
        @(negedge clk);
        walk_valid = 1'b0;
        for (int n = 0; n < 200; n++) begin
            if (done_valid) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!seen) chk("R12", "walk completion", 0, 1);
        r_fault = done_fault;
        r_fg    = done_fault_g;
        r_pa    = done_pa;
        r_pr    = perm_r;
        r_pw    = perm_w;
        r_px    = perm_x;
        @(negedge clk);
        chk("R12", "done is one pulse", done_valid, 0);
    endtask

    task automatic t_reset;
        chk("R12", "ready after reset", walk_ready, 1);
        chk("R12", "no request after reset", mem_req_valid, 0);
        chk("R12", "no done after reset", done_valid, 0);
    endtask

    task automatic t_s1_page;
        run(2'd0, 40'h00_0040_5123, 0, 0, 0, 0);
        chk("R1", "4K pa", r_pa, 34'h0_1234_5123);
        chk("R1", "4K fault", r_fault, 0);
        chk("R1", "reads", n_rd, 2);
        chk("R1", "root entry addr", rd_log[0], 34'h0_0010_0004);
        chk("R1", "leaf entry addr", rd_log[1], 34'h0_0040_0014);
        chk("R5", "rw perms", {r_pr, r_pw, r_px}, 3'b110);
    endtask

    task automatic t_s1_span;
        run(2'd0, 40'h01_0040_5123, 0, 0, 0, 0);
        chk("R2", "upper bits mismatch faults", r_fault, 1);
        chk("R2", "no read on range fault", n_rd, 0);
        chk("R2", "first-stage range not guest", r_fg, 0);
        run(2'd0, 40'hFF_8040_5123, 0, 0, 0, 0);
        chk("R2", "all-ones upper bits accepted", r_fault, 0);
        chk("R6", "first-stage superpage pa", r_pa, 34'h0_2AC0_5123);
        chk("R6", "superpage single read", n_rd, 1);
        chk("R5", "rx perms", {r_pr, r_pw, r_px}, 3'b101);
    endtask

    task automatic t_mxr;
        run(2'd0, 40'h00_0080_0000, 0, 0, 1, 0);
        chk("R5", "exec-only readable with mxr_s", r_pr, 1);
        run(2'd0, 40'h00_0080_0000, 0, 0, 0, 1);
        chk("R5", "mxr_vs ignored in first stage", r_pr, 0);
        chk("R5", "exec bit kept", r_px, 1);
    endtask

    task automatic t_faults;
        run(2'd0, 40'h00_00C0_0000, 0, 0, 0, 0);
        chk("R7", "invalid entry faults", r_fault, 1);
        run(2'd0, 40'h00_0100_0000, 0, 0, 0, 0);
        chk("R7", "write without read faults", r_fault, 1);
        chk("R7", "no perms on fault", {r_pr, r_pw, r_px}, 3'b000);
        run(2'd0, 40'h00_0180_0000, 0, 0, 0, 0);
        chk("R9", "misaligned superpage faults", r_fault, 1);
        run(2'd0, 40'h00_01C0_0000, 0, 0, 0, 0);
        chk("R8", "pointer at last level faults", r_fault, 1);
        chk("R8", "two reads before fault", n_rd, 2);
    endtask

    task automatic t_user;
        run(2'd0, 40'h00_0040_5123, 1, 0, 0, 0);
        chk("R13", "user on supervisor page faults", r_fault, 1);
        run(2'd0, 40'h00_0040_6000, 1, 0, 0, 0);
        chk("R13", "user on user page ok", r_fault, 0);
        chk("R13", "user page pa", r_pa, 34'h0_2222_2000);
    endtask

    task automatic t_s2_page;
        run(2'd1, 40'hFF_0040_2456, 0, 0, 0, 0);
        chk("R3", "guest walk fault", r_fault, 0);
        chk("R3", "widened root entry addr", rd_log[0], 34'h0_0030_3004);
        chk("R3", "second entry addr", rd_log[1], 34'h0_0060_0008);
        chk("R3", "guest pa", r_pa, 34'h0_0077_7456);
        run(2'd1, 40'h40_0040_2456, 0, 0, 0, 0);
        chk("R2", "guest range fault", {r_fault, r_fg}, 2'b11);
        chk("R2", "guest range no read", n_rd, 0);
    endtask

    task automatic t_s2_user;
        run(2'd1, 40'h00_0080_0000, 0, 0, 0, 0);
        chk("R4", "guest leaf without U faults", r_fault, 1);
        chk("R4", "guest fault flagged", r_fg, 1);
    endtask

    task automatic t_s2_super;
        run(2'd1, 40'hFF_0CC3_5ABC, 0, 0, 0, 0);
        chk("R6", "guest superpage root addr", rd_log[0], 34'h0_0030_30CC);
        chk("R6", "guest superpage widened merge", r_pa, 34'h0_45C3_5ABC);
        chk("R5", "guest read perm", {r_pr, r_pw, r_px}, 3'b100);
    endtask

    task automatic t_nest;
        run(2'd2, 40'h00_0040_7010, 0, 1, 0, 0);
        chk("R10", "nested fault", r_fault, 0);
        chk("R10", "nested reads", n_rd, 6);
        chk("R11", "vs root translated first", rd_log[1], 34'h0_0061_0800);
        chk("R10", "outer root entry uses translated base", rd_log[2], 34'h0_0088_0004);
        chk("R10", "second base translated", rd_log[4], 34'h0_0061_0840);
        chk("R10", "outer leaf entry addr", rd_log[5], 34'h0_0089_001C);
        chk("R10", "nested result", r_pa, 34'h0_0999_9010);
        run(2'd2, 40'h00_0040_7010, 0, 0, 0, 0);
        chk("R11", "root_s base translated", rd_log[1], 34'h0_0061_0400);
        chk("R10", "nested guest failure flags", {r_fault, r_fg}, 2'b11);
        chk("R10", "nested failure reads", n_rd, 2);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                n_checks++;
                $display("FAIL R12 watchdog: actual %0d expected <100000 cycles", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        mem[34'h0_0010_0004] = mk(22'h00400, 10'h001);
        mem[34'h0_0040_0014] = mk(22'h12345, 10'h007);
        mem[34'h0_0040_0018] = mk(22'h22222, 10'h013);
        mem[34'h0_0010_0804] = mk(22'h2AC00, 10'h00B);
        mem[34'h0_0010_0008] = mk(22'h00C00, 10'h009);
        mem[34'h0_0010_0010] = 32'h0000_0005;
        mem[34'h0_0010_0018] = mk(22'h00C01, 10'h003);
        mem[34'h0_0010_001C] = mk(22'h00500, 10'h001);
        mem[34'h0_0050_0000] = 32'h0000_0001;
        mem[34'h0_0030_3004] = mk(22'h00600, 10'h001);
        mem[34'h0_0060_0008] = mk(22'h00777, 10'h017);
        mem[34'h0_0030_0008] = mk(22'h00800, 10'h003);
        mem[34'h0_0030_30CC] = mk(22'h45000, 10'h013);
        mem[34'h0_0030_0000] = mk(22'h00610, 10'h001);
        mem[34'h0_0061_0800] = mk(22'h00880, 10'h013);
        mem[34'h0_0088_0004] = mk(22'h00210, 10'h001);
        mem[34'h0_0061_0840] = mk(22'h00890, 10'h013);
        mem[34'h0_0089_001C] = mk(22'h09999, 10'h007);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_s1_page();
        t_s1_span();
        t_mxr();
        t_faults();
        t_user();
        t_s2_page();
        t_s2_user();
        t_s2_super();
        t_nest();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule